// File: doc/BRIEF.md
# Submodule Pipeline Timing Reference

This block paces a converter valve model whose arithmetic runs as four parallel lanes, each lane taking one submodule capacitor per clock. Given the number of capacitors in the valve and a requested calculation-cycle length in clocks, it produces the references that downstream logic aligns to:

- a slot counter that steps once per clock across the calculation cycle;
- a group counter that steps once per completed cycle;
- a lane mask showing which lanes hold a real capacitor in the current slot;
- a strobe marking the slot that carries the last capacitor.

A cycle needs at least ceil(n/4) slots. When the requested length is longer than that, the slots after the last occupied one run with an empty mask. When it is shorter, the block stretches the cycle to the minimum and latches an error flag. Configuration is sampled every clock. Any change to either setting restarts both counters from zero.

Top module: `sm_timing_ref`

## Requirements
- R1: The effective cycle length is the largest of the configured length, ceil(n/4) and 1, where n is the configured capacitor count.
- R2: The slot counter advances by one each clock and returns to 0 on the clock after it reaches the effective length minus 1.
- R3: The group counter advances by one each time the slot counter returns to 0 from the last slot, counts 0,1,2,3 and then wraps to 0. At any other time it holds its value.
- R4: Lane mask bit k (bit 0 = lane 0) is 1 when slot*4 + k < n. So every slot below floor(n/4) carries mask 4'b1111.
- R5: When n is not a multiple of 4, slot floor(n/4) carries a mask whose n mod 4 low-order bits are 1 and whose other bits are 0. For example, n = 30 gives 4'b0011 at slot 7.
- R6: Every slot after the last occupied one carries mask 4'b0000. When n = 0, every slot does.
- R7: The end-of-cycle strobe is 1 exactly when n > 0 and the slot counter equals ceil(n/4)-1. Otherwise it is 0.
- R8: The error flag rises one clock after a configuration is accepted if the configured length is below max(ceil(n/4),1). The cycle is then clamped to that minimum. Once raised, the flag stays 1 until reset.
- R9: When either configuration input differs from the value currently in use, the next clock accepts the new value and both counters read 0.
- R10: While the synchronous active-low reset is applied, both counters, the mask, the strobe and the error flag read 0. The configuration in use becomes n = 0 with length 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_caps | input | CAP_W | Capacitor count n in the valve |
| cfg_ncc | input | NCC_W | Requested calculation-cycle length in clocks |
| slot_idx | output | NCC_W | Slot position within the current cycle |
| grp_idx | output | GRP_W | Cycle counter, modulo GROUPS |
| lane_mask | output | LANES | One bit per lane, 1 when the lane holds a capacitor |
| cycle_end | output | 1 | High on the slot carrying the last capacitor |
| cfg_err | output | 1 | Sticky flag: requested length was too short |

## Verification
The bench runs the counters and mask against a behavioural model under these configurations:

- Exact minimum length with a partial final slot (30 capacitors, 8 clocks). This separates the partial mask from the full mask.
- A stretched cycle (30 capacitors, 20 clocks). This exposes idle slots and checks that the strobe does not move to the cycle's last slot.
- A multiple of four (32 capacitors). Here no partial slot may appear.
- Tiny valves (one and five capacitors). A one-slot cycle makes the group counter step every clock.
- Zero capacitors. The mask and the strobe must stay silent.

A too-short length shows whether the cycle is clamped and whether the flag stays latched across a later legal configuration. Changes applied mid-cycle show the restart timing.

// File: rtl/sm_timing_pkg.sv
// Package: shared arithmetic helpers for the submodule timing reference.
// Assumes all counts fit in 31 bits; callers widen to 32 bits before use.
package sm_timing_pkg;

    // Number of slots needed to hold 'items' spread over 'lanes' per slot.
    function automatic int unsigned ceil_div(input int unsigned items,
                                             input int unsigned lanes);
        return (items + lanes - 1) / lanes;
    endfunction

    // Minimum legal cycle length: never below one slot.
    function automatic int unsigned min_cycle(input int unsigned caps,
                                              input int unsigned lanes);
        int unsigned s;
        s = ceil_div(caps, lanes);
        return (s == 0) ? 1 : s;
    endfunction

    // True when lane 'lane' of slot 'slot' carries a real capacitor.
    function automatic logic lane_busy(input int unsigned slot,
                                       input int unsigned lane,
                                       input int unsigned caps,
                                       input int unsigned lanes);
        return (slot * lanes + lane) < caps;
    endfunction

endpackage

// File: rtl/sm_cfg_guard.sv
// Module: sm_cfg_guard
// Holds the configuration in use and detects changes on the inputs.
// Produces the clamped cycle length and a sticky error flag.
// Assumes NCC_W is wide enough to hold ceil(2**CAP_W / LANES).
module sm_cfg_guard
    import sm_timing_pkg::*;
#(
    parameter int CAP_W = 10,
    parameter int NCC_W = 10,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CAP_W-1:0] cfg_caps,
    input  logic [NCC_W-1:0] cfg_ncc,
    output logic [CAP_W-1:0] cap_q,
    output logic [NCC_W-1:0] ncc_eff,
    output logic             restart,
    output logic             cfg_err
);

    logic [NCC_W-1:0] ncc_raw_q;
    logic             too_short;
    int unsigned      need;

    // Flag a configuration change against the held copy.
    always_comb begin
        restart = (cfg_caps != cap_q) || (cfg_ncc != ncc_raw_q);
    end

    // Compute the minimum length and clamp the requested length to it.
    always_comb begin
        need      = min_cycle(32'(cap_q), LANES);
        too_short = 32'(ncc_raw_q) < need;
        ncc_eff   = too_short ? NCC_W'(need) : ncc_raw_q;
    end

    // Capture a new configuration whenever the inputs differ.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q     <= '0;
            ncc_raw_q <= NCC_W'(1);
        end else if (restart) begin
            cap_q     <= cfg_caps;
            ncc_raw_q <= cfg_ncc;
        end
    end

    // Latch the error flag until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else if (too_short) begin
            cfg_err <= 1'b1;
        end
    end

endmodule

// File: rtl/sm_slot_counter.sv
// Module: sm_slot_counter
// Slot counter over one calculation cycle and a group counter that
// steps once per cycle. Assumes ncc_eff >= 1 and GROUPS >= 2.
module sm_slot_counter #(
    parameter int NCC_W  = 10,
    parameter int GROUPS = 4,
    localparam int GRP_W = $clog2(GROUPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [NCC_W-1:0] ncc_eff,
    output logic [NCC_W-1:0] slot_idx,
    output logic [GRP_W-1:0] grp_idx
);

    logic at_last;
    logic grp_top;

    // Detect the final slot of the cycle and the final group value.
    always_comb begin
        at_last = (32'(slot_idx) + 32'd1) == 32'(ncc_eff);
        grp_top = 32'(grp_idx) == (GROUPS - 1);
    end

    // Advance, wrap or restart the slot counter.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            slot_idx <= '0;
        end else if (at_last) begin
            slot_idx <= '0;
        end else begin
            slot_idx <= slot_idx + 1'b1;
        end
    end

    // Step the group counter on each cycle wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            grp_idx <= '0;
        end else if (at_last) begin
            grp_idx <= grp_top ? '0 : grp_idx + 1'b1;
        end
    end

endmodule

// File: rtl/sm_lane_mask.sv
// Module: sm_lane_mask
// Combinational lane-occupancy mask and last-capacitor strobe for the
// current slot. Assumes the slot stays below the clamped cycle length.
module sm_lane_mask
    import sm_timing_pkg::*;
#(
    parameter int CAP_W = 10,
    parameter int NCC_W = 10,
    parameter int LANES = 4
) (
    input  logic [CAP_W-1:0] cap_q,
    input  logic [NCC_W-1:0] slot_idx,
    output logic [LANES-1:0] lane_mask,
    output logic             cycle_end
);

    // One occupancy decision per lane.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            lane_mask[l] = lane_busy(32'(slot_idx), l, 32'(cap_q), LANES);
        end
    end

    // Strobe on the slot holding the final capacitor.
    always_comb begin
        cycle_end = (cap_q != '0) &&
                    (32'(slot_idx) == ceil_div(32'(cap_q), LANES) - 1);
    end

endmodule

// File: rtl/sm_timing_ref.sv
// Module: sm_timing_ref (top)
// Timing reference for a lane-parallel submodule pipeline: slot counter,
// group counter, lane mask, end-of-cycle strobe, configuration guard.
// Assumes configuration inputs are synchronous to clk.
module sm_timing_ref #(
    parameter int CAP_W  = 10,
    parameter int NCC_W  = 10,
    parameter int LANES  = 4,
    parameter int GROUPS = 4,
    localparam int GRP_W = $clog2(GROUPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CAP_W-1:0] cfg_caps,
    input  logic [NCC_W-1:0] cfg_ncc,
    output logic [NCC_W-1:0] slot_idx,
    output logic [GRP_W-1:0] grp_idx,
    output logic [LANES-1:0] lane_mask,
    output logic             cycle_end,
    output logic             cfg_err
);

    logic [CAP_W-1:0] cap_q;
    logic [NCC_W-1:0] ncc_eff;
    logic             restart;

    sm_cfg_guard #(.CAP_W(CAP_W), .NCC_W(NCC_W), .LANES(LANES)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_caps (cfg_caps),
        .cfg_ncc  (cfg_ncc),
        .cap_q    (cap_q),
        .ncc_eff  (ncc_eff),
        .restart  (restart),
        .cfg_err  (cfg_err)
    );

    sm_slot_counter #(.NCC_W(NCC_W), .GROUPS(GROUPS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .ncc_eff  (ncc_eff),
        .slot_idx (slot_idx),
        .grp_idx  (grp_idx)
    );

    sm_lane_mask #(.CAP_W(CAP_W), .NCC_W(NCC_W), .LANES(LANES)) u_mask (
        .cap_q     (cap_q),
        .slot_idx  (slot_idx),
        .lane_mask (lane_mask),
        .cycle_end (cycle_end)
    );

endmodule

// File: rtl/sm_timing_ref_chk.sv
// Module: sm_timing_ref_chk
// Property checker bound to sm_timing_ref; observes its ports only.
module sm_timing_ref_chk #(
    parameter int NCC_W  = 10,
    parameter int LANES  = 4,
    parameter int GRP_W  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCC_W-1:0] slot_idx,
    input logic [GRP_W-1:0] grp_idx,
    input logic [LANES-1:0] lane_mask,
    input logic             cycle_end,
    input logic             cfg_err
);

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx != '0) |-> (slot_idx == $past(slot_idx) + 1'b1)); // R2

    AST_GRP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx != '0) |-> $stable(grp_idx)); // R3

    AST_MASK_LOW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (((lane_mask + 1'b1) & lane_mask) == '0)); // R5

    AST_END_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end |-> lane_mask[0]); // R7

    AST_IDLE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cycle_end) && slot_idx != '0) |-> (lane_mask == '0)); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_err) |-> cfg_err); // R8

endmodule

bind sm_timing_ref sm_timing_ref_chk #(
    .NCC_W (NCC_W),
    .LANES (LANES),
    .GRP_W (GRP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_idx  (slot_idx),
    .grp_idx   (grp_idx),
    .lane_mask (lane_mask),
    .cycle_end (cycle_end),
    .cfg_err   (cfg_err)
);

// File: tb/sm_timing_ref_test.sv
`timescale 1ns/1ps
module sm_timing_ref_test;

    localparam int CAP_W = 10;
    localparam int NCC_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CAP_W-1:0] cfg_caps = '0;
    logic [NCC_W-1:0] cfg_ncc = '0;
    logic [NCC_W-1:0] slot_idx;
    logic [1:0]       grp_idx;
    logic [3:0]       lane_mask;
    logic             cycle_end;
    logic             cfg_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    // Behavioural model state
    int m_cap = 0, m_ncc = 1, m_slot = 0, m_grp = 0;
    bit m_err = 0;

    always #2.5 clk = ~clk;

    sm_timing_ref uut (
        .clk(clk), .rst_n(rst_n), .cfg_caps(cfg_caps), .cfg_ncc(cfg_ncc),
        .slot_idx(slot_idx), .grp_idx(grp_idx), .lane_mask(lane_mask),
        .cycle_end(cycle_end), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
        end
    endtask

    // Model update on each rising edge.
    always @(posedge clk) begin
        int need, eff;
        if (!rst_n) begin
            m_cap = 0; m_ncc = 1; m_slot = 0; m_grp = 0; m_err = 0;
        end else begin
            need = (m_cap + 3) / 4;
            if (need < 1) need = 1;
            eff = (m_ncc < need) ? need : m_ncc;
            if (m_ncc < need) m_err = 1;
            if (int'(cfg_caps) != m_cap || int'(cfg_ncc) != m_ncc) begin
                m_cap = cfg_caps; m_ncc = cfg_ncc; m_slot = 0; m_grp = 0;
            end else if (m_slot == eff - 1) begin
                m_slot = 0; m_grp = (m_grp + 1) % 4;
            end else begin
                m_slot++;
            end
        end
    end

    // Compare every output on each falling edge.
    always @(negedge clk) begin
        int exp_mask;
        bit exp_end;
        if (!done) begin
            exp_mask = 0;
            for (int l = 0; l < 4; l++)
                if (m_slot * 4 + l < m_cap) exp_mask |= (1 << l);
            exp_end = (m_cap > 0) && (m_slot == (m_cap - 1) / 4);
            check(int'(slot_idx) == m_slot, "R1 R2 slot counter", slot_idx, m_slot);
            check(int'(grp_idx) == m_grp, "R3 group counter", grp_idx, m_grp);
            check(int'(lane_mask) == exp_mask, "R4 R5 R6 lane mask", lane_mask, exp_mask);
            check(cycle_end == exp_end, "R7 end strobe", cycle_end, exp_end);
            check(cfg_err == m_err, "R8 error flag", cfg_err, m_err);
        end
    end

    task automatic apply(input int caps, input int ncc);
        @(negedge clk);
        cfg_caps = CAP_W'(caps);
        cfg_ncc  = NCC_W'(ncc);
    endtask

    task automatic finish_run();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(slot_idx == 0 && grp_idx == 0 && lane_mask == 0 && !cycle_end && !cfg_err,
              "R10 reset state", {slot_idx, grp_idx, lane_mask}, 0);
        rst_n = 1'b1;
        apply(30, 8);
        @(negedge clk);
        check(slot_idx == 0, "R9 restart after config", slot_idx, 0);
        repeat (7) @(negedge clk);
        check(lane_mask == 4'b0011 && cycle_end, "R5 partial final slot", lane_mask, 3);
        repeat (40) @(negedge clk);
        apply(30, 20);              // stretched cycle, idle slots
        repeat (70) @(negedge clk);
        apply(32, 8);               // exact multiple of four
        repeat (40) @(negedge clk);
        apply(5, 3);
        repeat (20) @(negedge clk);
        apply(1, 1);                // one-slot cycle
        repeat (12) @(negedge clk);
        check(grp_idx == 3, "R3 group steps every clock", grp_idx, 3);
        apply(0, 4);                // no capacitors
        repeat (12) @(negedge clk);
        // R9: mid-cycle change restarts counters
        apply(30, 20);
        repeat (5) @(negedge clk);
        apply(30, 21);
        @(negedge clk);
        check(slot_idx == 0 && grp_idx == 0, "R9 mid-cycle restart", slot_idx, 0);
        repeat (30) @(negedge clk);
        // R8: too-short length clamps and latches
        apply(30, 5);
        repeat (2) @(negedge clk);
        check(cfg_err == 1'b1, "R8 error raised", cfg_err, 1);
        repeat (30) @(negedge clk);
        apply(16, 6);
        repeat (20) @(negedge clk);
        check(cfg_err == 1'b1, "R8 error sticky", cfg_err, 1);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(cfg_err == 1'b0 && slot_idx == 0, "R10 reset clears flag", cfg_err, 0);
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        finish_run();
    end

endmodule